// File: doc/BRIEF.md
# Object Attribute Address Mapper

This block is the single path by which a processor and a set of functional units read and write object attributes held in one shared word-addressed memory. A requester presents a 32-bit object-relative address made of a class identifier, an object number and an attribute index. The class and the object number together select an entry in a translation table. The entry gives the object's base word and its size in words. The physical word is the base plus the index.

Requesters are served one at a time. A round-robin arbiter picks at most one requester per cycle. The chosen request is translated and bounds-checked, and then makes a single memory access. A response then goes back to the winning requester: read data for a read, or an acknowledge for a write, together with an error flag.

Software sets up the table through a separate configuration port before it uses an object. Objects of one class share a layout and size. A derived-class object is given a larger size, with its inherited attributes at the low indices and its own attributes after them.

Top module: `omap_mapper`

## Requirements
- R1: The request address splits as class [31:28], object number [27:24] and index [23:0]. The 8-bit object identifier {class, object} selects the table entry, so objects that differ only in class map through different entries.
- R2: When `cfg_we_i` is high at a clock edge, the entry for `cfg_oid_i` takes `cfg_base_i` and `cfg_size_i`. A request accepted at that edge or later is translated with the new entry.
- R3: In any cycle, at most one bit of `req_ready_o` is high, and only for a requester whose valid is high. A request is accepted at a clock edge where its valid and ready bits are both high.
- R4: Arbitration is round-robin. After reset, port 0 has the highest priority. After port i is served, the search starts at port i+1 and wraps around. Port 0 is the processor; ports 1 and up are the functional units.
- R5: The physical word address is (base + index) modulo the memory depth. A write stores the write data at that word. A read returns the word stored there.
- R6: A request accepted at edge E is answered in the cycle after edge E+1. In that cycle, only the accepted port's bit of `rsp_valid_o` is high. Writes are answered as well, with read data 0.
- R7: An index greater than or equal to the entry's size raises `rsp_err_o` in the response. Such a write leaves the memory unchanged, and such a read returns data 0.
- R8: After reset, every table size is 0, so every access reports an error. No ready or response is raised while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_FU+1 | Request valid per requester (bit 0 is the processor) |
| req_ready_o | output | N_FU+1 | Request accepted this cycle, one-hot or zero |
| req_we_i | input | N_FU+1 | 1 = write, 0 = read, per requester |
| req_addr_i | input | 32*(N_FU+1) | Object-relative address per requester |
| req_wdata_i | input | DATA_W*(N_FU+1) | Write data per requester |
| rsp_valid_o | output | N_FU+1 | Response strobe for the served requester |
| rsp_rdata_o | output | DATA_W | Read data for the response |
| rsp_err_o | output | 1 | Index out of range for the answered request |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_oid_i | input | 8 | Entry selected as {class, object} |
| cfg_base_i | input | MEM_AW | Base word of the object |
| cfg_size_i | input | 24 | Object size in words |

## Verification
The assertions check three things on every cycle: that grants are one-hot, that a grant only goes to a requester asking for one, and that every accepted request returns a response to the same port exactly two edges later. The data path can only be shown by the bench's scenarios. These cover translation through each object's own entry, address wrap-around, reconfiguring an entry, suppressed out-of-range writes whose neighbouring word must still read back intact, and the order in which contending ports are served from different pointer positions.

// File: rtl/omap_pkg.sv
package omap_pkg;
  localparam int CLS_W = 4;
  localparam int OBJ_W = 4;
  localparam int IDX_W = 24;
  localparam int VA_W  = CLS_W + OBJ_W + IDX_W;
  localparam int OID_W = CLS_W + OBJ_W;
  localparam int N_OID = 1 << OID_W;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic [OBJ_W-1:0] obj;
    logic [IDX_W-1:0] idx;
  } vaddr_t;
endpackage

// File: rtl/omap_rr_arb.sv
module omap_rr_arb #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  valid_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] win_o
);
  logic [IW-1:0] ptr_q;
  logic          found;
  int            c;

  always_comb begin
    grant_o = '0;
    win_o   = '0;
    found   = 1'b0;
    c       = 0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr_q) + k;
      if (c >= N) c = c - N;
      if (!found && valid_i[c]) begin
        found      = 1'b1;
        grant_o[c] = 1'b1;
        win_o      = IW'(c);
      end
    end
  end

  // R4: search restarts just past the last winner
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (found) ptr_q <= (win_o == IW'(N-1)) ? '0 : win_o + IW'(1);
  end

  a_r3_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  a_r3_grant_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~valid_i) == '0);
endmodule

// File: rtl/omap_xlate.sv
module omap_xlate
  import omap_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [OID_W-1:0]  cfg_oid_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [IDX_W-1:0]  cfg_size_i,
  input  logic [OID_W-1:0]  look_oid_i,
  input  logic [IDX_W-1:0]  look_idx_i,
  output logic [BASE_W-1:0] phys_o,
  output logic              err_o
);
  logic [BASE_W-1:0] base_q [N_OID];
  logic [IDX_W-1:0]  size_q [N_OID];

  // R2, R8: table cleared by reset, written by the configuration port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_OID; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else if (cfg_we_i) begin
      base_q[cfg_oid_i] <= cfg_base_i;
      size_q[cfg_oid_i] <= cfg_size_i;
    end
  end

  // R5, R7: base plus index wraps in memory depth; bounds against size
  assign phys_o = base_q[look_oid_i] + look_idx_i[BASE_W-1:0];
  assign err_o  = (look_idx_i >= size_q[look_oid_i]);
endmodule

// File: rtl/omap_store.sv
module omap_store #(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/omap_mapper.sv
module omap_mapper
  import omap_pkg::*;
#(
  parameter int N_FU   = 2,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8,
  localparam int N_REQ = N_FU + 1,
  localparam int IW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_REQ-1:0]        req_valid_i,
  output logic [N_REQ-1:0]        req_ready_o,
  input  logic [N_REQ-1:0]        req_we_i,
  input  logic [N_REQ*VA_W-1:0]   req_addr_i,
  input  logic [N_REQ*DATA_W-1:0] req_wdata_i,
  output logic [N_REQ-1:0]        rsp_valid_o,
  output logic [DATA_W-1:0]       rsp_rdata_o,
  output logic                    rsp_err_o,
  input  logic                    cfg_we_i,
  input  logic [OID_W-1:0]        cfg_oid_i,
  input  logic [MEM_AW-1:0]       cfg_base_i,
  input  logic [IDX_W-1:0]        cfg_size_i
);
  logic [IW-1:0] win;

  omap_rr_arb #(.N(N_REQ), .IW(IW)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .grant_o (req_ready_o),
    .win_o   (win)
  );

  // stage 1: accepted request
  logic              s1_valid, s1_we;
  logic [IW-1:0]     s1_win;
  vaddr_t            s1_va;
  logic [DATA_W-1:0] s1_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_we    <= 1'b0;
      s1_win   <= '0;
      s1_va    <= '0;
      s1_wdata <= '0;
    end else begin
      s1_valid <= |req_ready_o;
      if (|req_ready_o) begin
        s1_we    <= req_we_i[win];
        s1_win   <= win;
        s1_va    <= req_addr_i[win*VA_W +: VA_W];
        s1_wdata <= req_wdata_i[win*DATA_W +: DATA_W];
      end
    end
  end

  logic [MEM_AW-1:0] phys;
  logic              s1_err;

  omap_xlate #(.BASE_W(MEM_AW)) u_xlate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_oid_i  (cfg_oid_i),
    .cfg_base_i (cfg_base_i),
    .cfg_size_i (cfg_size_i),
    .look_oid_i ({s1_va.cls, s1_va.obj}),
    .look_idx_i (s1_va.idx),
    .phys_o     (phys),
    .err_o      (s1_err)
  );

  logic [DATA_W-1:0] mem_rdata;

  // R7: out-of-range writes never reach the memory
  omap_store #(.AW(MEM_AW), .DW(DATA_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (s1_valid & s1_we & ~s1_err),
    .addr_i  (phys),
    .wdata_i (s1_wdata),
    .rdata_o (mem_rdata)
  );

  // stage 2: response
  logic          s2_valid, s2_err, s2_rd;
  logic [IW-1:0] s2_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_err   <= 1'b0;
      s2_rd    <= 1'b0;
      s2_win   <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_err   <= s1_err;
      s2_rd    <= ~s1_we;
      s2_win   <= s1_win;
    end
  end

  always_comb begin
    rsp_valid_o = '0;
    if (s2_valid) rsp_valid_o[s2_win] = 1'b1;
  end
  assign rsp_err_o   = s2_valid & s2_err;
  assign rsp_rdata_o = (s2_valid && s2_rd && !s2_err) ? mem_rdata : '0;

  a_r6_rsp_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_o));
  a_r6_rsp_to_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_ready_o) |=> ##1 (rsp_valid_o == $past(req_ready_o, 2)));
endmodule

// File: tb/sim_omap_mapper.sv
`timescale 1ns/1ps
module sim_omap_mapper;
  localparam int NR = 3;
  localparam int DW = 32;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NR-1:0]   r_valid = '0, r_we = '0, r_ready, s_valid;
  logic [NR*32-1:0] r_addr = '0;
  logic [NR*DW-1:0] r_wdata = '0;
  logic [DW-1:0]   s_rdata;
  logic            s_err;
  logic            c_we = 1'b0;
  logic [7:0]      c_oid = '0;
  logic [AW-1:0]   c_base = '0;
  logic [23:0]     c_size = '0;

  always #2 clk = ~clk;

  omap_mapper #(.N_FU(NR-1), .DATA_W(DW), .MEM_AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(r_valid), .req_ready_o(r_ready), .req_we_i(r_we),
    .req_addr_i(r_addr), .req_wdata_i(r_wdata),
    .rsp_valid_o(s_valid), .rsp_rdata_o(s_rdata), .rsp_err_o(s_err),
    .cfg_we_i(c_we), .cfg_oid_i(c_oid), .cfg_base_i(c_base), .cfg_size_i(c_size)
  );

  typedef struct {
    logic [DW-1:0] d;
    logic          e;
    int            due;
    string         tag;
  } exp_t;

  exp_t q[NR][$];
  int   checks = 0, fails = 0, cyc = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare responses with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NR; p++) begin
        if (s_valid[p]) begin
          if (q[p].size() == 0) chk(0, "R6 unexpected response", p, 0);
          else begin
            exp_t x;
            x = q[p].pop_front();
            chk(cyc == x.due, "R6 latency", cyc, x.due);
            chk(s_rdata == x.d && s_err == x.e, x.tag, {s_err, s_rdata}, {x.e, x.d});
          end
        end
      end
    end
  end

  // R3: grant shape checked between edges
  always @(negedge clk) begin
    #1;
    if (rst_n && r_valid != 0)
      chk($countones(r_ready) <= 1 && (r_ready & ~r_valid) == 0, "R3 grant shape", r_ready, r_valid);
  end

  task automatic issue(input int p, input logic [3:0] c, input logic [3:0] o,
                       input logic [23:0] ix, input logic we, input logic [31:0] wd,
                       input logic [31:0] ed, input logic ee, input string tag,
                       output int acc);
    bit   got;
    exp_t x;
    @(negedge clk);
    r_valid[p] = 1'b1;
    r_we[p]    = we;
    r_addr[p*32 +: 32]  = {c, o, ix};
    r_wdata[p*DW +: DW] = wd;
    got = 0;
    while (!got) begin
      #1;
      got = r_ready[p];
      @(negedge clk);
    end
    acc = cyc;
    x.d = ed; x.e = ee; x.due = cyc + 1; x.tag = tag;
    q[p].push_back(x);
    r_valid[p] = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] c, input logic [3:0] o, input logic [AW-1:0] b, input logic [23:0] s);
    @(negedge clk);
    c_we = 1'b1; c_oid = {c, o}; c_base = b; c_size = s;
    @(negedge clk);
    c_we = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int a0, a1, a2;
    repeat (3) @(negedge clk);
    chk(r_ready == 0 && s_valid == 0, "R8 idle after reset", {r_ready, s_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(r_ready == 0 && s_valid == 0, "R8 idle without request", {r_ready, s_valid}, 0);
    issue(0, 4'd3, 4'd1, 24'd0, 1'b0, 0, 32'h0, 1'b1, "R8 unconfigured entry errors", a0);

    cfg(4'd1, 4'd2, 8'd16, 24'd8);
    cfg(4'd1, 4'd3, 8'd24, 24'd4);
    cfg(4'd2, 4'd0, 8'd250, 24'd10);
    cfg(4'd0, 4'd0, 8'd0, 24'd4);

    issue(0, 4'd1, 4'd2, 24'd3, 1'b1, 32'hA5A5_0001, 32'h0, 1'b0, "R6 write acknowledge", a0);
    issue(1, 4'd1, 4'd2, 24'd3, 1'b0, 0, 32'hA5A5_0001, 1'b0, "R5 read back", a0);
    issue(2, 4'd1, 4'd3, 24'd0, 1'b1, 32'h0000_1111, 32'h0, 1'b0, "R1 write other entry", a0);
    issue(0, 4'd1, 4'd3, 24'd0, 1'b0, 0, 32'h0000_1111, 1'b0, "R1 separate object entry", a0);
    issue(1, 4'd1, 4'd2, 24'd7, 1'b1, 32'h7777_0007, 32'h0, 1'b0, "R5 last in-range word", a0);
    issue(0, 4'd1, 4'd3, 24'd0, 1'b0, 0, 32'h0000_1111, 1'b0, "R1 neighbour intact", a0);

    issue(0, 4'd2, 4'd0, 24'd8, 1'b1, 32'hBEEF_0002, 32'h0, 1'b0, "R5 wrap write", a0);
    issue(2, 4'd0, 4'd0, 24'd2, 1'b0, 0, 32'hBEEF_0002, 1'b0, "R5 wrapped word", a0);

    issue(1, 4'd1, 4'd2, 24'd8, 1'b1, 32'hDEAD_DEAD, 32'h0, 1'b1, "R7 write at size", a0);
    issue(0, 4'd1, 4'd3, 24'd0, 1'b0, 0, 32'h0000_1111, 1'b0, "R7 write suppressed", a0);
    issue(2, 4'd1, 4'd2, 24'hFF_FFFF, 1'b0, 0, 32'h0, 1'b1, "R7 read far out of range", a0);

    // R4: pointer at 0 after port 2 wins
    issue(2, 4'd0, 4'd0, 24'd2, 1'b0, 0, 32'hBEEF_0002, 1'b0, "R4 prime", a0);
    fork
      issue(0, 4'd1, 4'd2, 24'd3, 1'b0, 0, 32'hA5A5_0001, 1'b0, "R4 data p0", a0);
      issue(1, 4'd1, 4'd2, 24'd7, 1'b0, 0, 32'h7777_0007, 1'b0, "R4 data p1", a1);
      issue(2, 4'd1, 4'd3, 24'd0, 1'b0, 0, 32'h0000_1111, 1'b0, "R4 data p2", a2);
    join
    chk(a1 == a0 + 1 && a2 == a1 + 1, "R4 order 0,1,2", {a0[15:0], a1[15:0], a2[15:0]}, 0);

    // R4: pointer at 2 after port 1 wins
    issue(1, 4'd0, 4'd0, 24'd2, 1'b0, 0, 32'hBEEF_0002, 1'b0, "R4 prime", a0);
    fork
      issue(0, 4'd1, 4'd2, 24'd3, 1'b0, 0, 32'hA5A5_0001, 1'b0, "R4 data p0", a0);
      issue(1, 4'd1, 4'd2, 24'd7, 1'b0, 0, 32'h7777_0007, 1'b0, "R4 data p1", a1);
      issue(2, 4'd1, 4'd3, 24'd0, 1'b0, 0, 32'h0000_1111, 1'b0, "R4 data p2", a2);
    join
    chk(a0 == a2 + 1 && a1 == a0 + 1, "R4 order 2,0,1", {a0[15:0], a1[15:0], a2[15:0]}, 0);

    // R2: remap entry {0,0} onto the first object's words
    cfg(4'd0, 4'd0, 8'd16, 24'd8);
    issue(0, 4'd0, 4'd0, 24'd3, 1'b0, 0, 32'hA5A5_0001, 1'b0, "R2 remapped base", a0);
    issue(1, 4'd0, 4'd0, 24'd7, 1'b0, 0, 32'h7777_0007, 1'b0, "R2 remapped size", a0);

    repeat (4) @(negedge clk);
    for (int p = 0; p < NR; p++)
      chk(q[p].size() == 0, "R6 missing response", q[p].size(), 0);
    finish_run();
  end
endmodule